// File: doc/BRIEF.md
# Speculative Miss Value Controller

This block sits beside the second-level cache and the reorder buffer of an out-of-order core. When a load misses in the L2, the block reads a last-value predictor indexed by the load's PC. In the same cycle it hands the core a predicted value and a tracking tag, so the load does not stall. When that load becomes the oldest instruction, the block makes sure a register-state checkpoint exists and then lets the load retire on its predicted value. Execution carries on speculatively past the load.

When the memory data for a tracked address comes back, the block compares it against the stored prediction. A match frees the tracking entry. Once no retired-but-unverified load remains, the checkpoint is released with a commit pulse. A mismatch raises a rollback pulse, drops the checkpoint and discards every tracked load. If data returns before its load reaches the head, the load is verified immediately and retires later without a checkpoint. The predictor only needs to be right about half the time; a wrong guess costs a rollback but never a wrong result.

Top module: `miss_value_spec`

## Requirements
- R1: When `missValid` is high and an entry is free, `predValid` is high in the same cycle. `predValue` equals the predictor entry indexed by `missPc[7:2]`, and `predTag` is the lowest-numbered free entry. After reset every predictor entry reads zero.
- R2: Every fill whose address matches a tracked entry (waiting or retired) writes `fillData` into the predictor entry of that load's PC, whether or not it matched the prediction.
- R3: At most 4 loads are tracked. A miss with all 4 entries busy gets `predValid` low and `missStall` high, and is not tracked.
- R4: A one-cycle `robHeadValid` for a waiting entry, with no checkpoint held, raises `ckptReq` from the next cycle. `ckptReq` stays high until the cycle in which `ckptAck` is seen. `ckptReq` is low after reset.
- R5: In the cycle after `ckptAck`, `retireValid` pulses with `retireTag` set to that load's tag and `retireValue` set to its predicted value. The checkpoint is then held.
- R6: A head notification for a waiting entry while a checkpoint is held retires it in the next cycle without a new `ckptReq`.
- R7: A fill that matches the prediction before the load reaches the head verifies it at once with no pulse. The later head notification retires it in the next cycle and never raises `ckptReq`.
- R8: A matching fill for a retired load frees its entry. `commitValid` pulses in the next cycle if a checkpoint is held and no retired, unverified load remains.
- R9: A fill that differs from the prediction of any tracked entry pulses `rollbackValid` in the next cycle. It clears all entries (the next miss gets tag 0), drops the checkpoint, withdraws a pending `ckptReq`, and suppresses commit in that cycle.
- R10: A fill whose address matches no tracked entry causes no retire, commit or rollback pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | An L2 load miss is presented |
| missPc | input | 32 | PC of the missing load |
| missAddr | input | 32 | Address of the missing line |
| predValid | output | 1 | A prediction and tag are issued this cycle |
| predValue | output | 32 | Predicted load value |
| predTag | output | 2 | Tracking tag given to the load |
| missStall | output | 1 | No entry free; the load stalls normally |
| robHeadValid | input | 1 | Pulse: a tracked load reached the reorder buffer head |
| robHeadTag | input | 2 | Tag of that load |
| ckptReq | output | 1 | Request to take a state checkpoint |
| ckptAck | input | 1 | Checkpoint has been taken |
| retireValid | output | 1 | Pulse: the load may retire |
| retireTag | output | 2 | Tag of the retiring load |
| retireValue | output | 32 | Value the load retires with |
| fillValid | input | 1 | Memory data arrives at the L2 |
| fillAddr | input | 32 | Address of the returned line |
| fillData | input | 32 | Returned load value |
| commitValid | output | 1 | Pulse: speculation confirmed, checkpoint released |
| rollbackValid | output | 1 | Pulse: restart from the checkpoint |

## Verification
The hardest case to reach from the ports is a checkpoint covering more than one load. That needs a second load to retire while an older load is still unverified, followed by a wrong fill for the younger one. The stimulus builds it in order: it issues two misses and retires the first through a checkpoint handshake. It then retires the second directly, confirms the first with no commit, and sends a mismatching fill for the second. A rollback that arrives while a checkpoint request is still open, and the early-fill path that skips the checkpoint, are each reached with their own short sequences.

// File: rtl/mvp_pkg.sv
package mvp_pkg;
  typedef enum logic [1:0] {SLOT_FREE, SLOT_PEND, SLOT_SPEC, SLOT_DONE} slotSt_e;
  typedef enum logic {CTL_IDLE, CTL_CKWAIT} ctlSt_e;
  typedef struct packed {
    logic allocEn;
    logic tblWrEn;
  } dpStrobe_t;
endpackage

// File: rtl/mvp_datapath.sv
module mvp_datapath #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PC_W = 32,
  parameter int TBL_DEPTH = 64,
  parameter int MAX_OUT = 4,
  parameter int PC_LSB = 2,
  localparam int TAG_W = $clog2(MAX_OUT),
  localparam int IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mvp_pkg::dpStrobe_t    strobe,
  input  logic [TAG_W-1:0]      allocSlot,
  input  logic [TAG_W-1:0]      tblSlot,
  input  logic [TAG_W-1:0]      rdSlot,
  input  logic [PC_W-1:0]       missPc,
  input  logic [ADDR_W-1:0]     missAddr,
  input  logic [ADDR_W-1:0]     fillAddr,
  input  logic [DATA_W-1:0]     fillData,
  output logic [DATA_W-1:0]     predValue,
  output logic [MAX_OUT-1:0]    addrHit,
  output logic [MAX_OUT-1:0]    dataEq,
  output logic [DATA_W-1:0]     rdValue
);
  logic [DATA_W-1:0] lvTable [TBL_DEPTH];
  logic [ADDR_W-1:0] slotAddr [MAX_OUT];
  logic [DATA_W-1:0] slotPred [MAX_OUT];
  logic [IDX_W-1:0]  slotIdx  [MAX_OUT];
  logic [IDX_W-1:0]  missIdx;

  assign missIdx   = missPc[PC_LSB +: IDX_W];
  assign predValue = lvTable[missIdx];
  assign rdValue   = slotPred[rdSlot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < TBL_DEPTH; e++) lvTable[e] <= '0;
    end else if (strobe.tblWrEn) begin
      lvTable[slotIdx[tblSlot]] <= fillData;
    end
  end

  generate
    for (genvar s = 0; s < MAX_OUT; s++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotAddr[s] <= '0;
          slotPred[s] <= '0;
          slotIdx[s]  <= '0;
        end else if (strobe.allocEn && allocSlot == TAG_W'(s)) begin
          slotAddr[s] <= missAddr;
          slotPred[s] <= predValue;
          slotIdx[s]  <= missIdx;
        end
      end
      assign addrHit[s] = (slotAddr[s] == fillAddr);
      assign dataEq[s]  = (slotPred[s] == fillData);
    end
  endgenerate
endmodule

// File: rtl/mvp_control.sv
module mvp_control #(
  parameter int MAX_OUT = 4,
  localparam int TAG_W = $clog2(MAX_OUT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               missValid,
  input  logic               robHeadValid,
  input  logic [TAG_W-1:0]   robHeadTag,
  input  logic               ckptAck,
  input  logic               fillValid,
  input  logic [MAX_OUT-1:0] addrHit,
  input  logic [MAX_OUT-1:0] dataEq,
  output mvp_pkg::dpStrobe_t strobe,
  output logic [TAG_W-1:0]   allocSlot,
  output logic [TAG_W-1:0]   tblSlot,
  output logic               predValid,
  output logic               missStall,
  output logic               ckptReq,
  output logic               retireValid,
  output logic [TAG_W-1:0]   retireTag,
  output logic               commitValid,
  output logic               rollbackValid
);
  import mvp_pkg::*;

  slotSt_e slotSt [MAX_OUT];
  slotSt_e nxtSt  [MAX_OUT];
  ctlSt_e  ctlSt, nxtCtl;
  logic    ckptHeld, nxtHeld;
  logic [TAG_W-1:0] waitTag, nxtWait;
  logic [MAX_OUT-1:0] hitVec;
  logic anyFree, badFill, anySpecNxt, retireNow, commitNow;
  logic [TAG_W-1:0] retTagNow;

  always_comb begin
    anyFree = 1'b0;
    allocSlot = '0;
    for (int s = MAX_OUT - 1; s >= 0; s--) begin
      if (slotSt[s] == SLOT_FREE) begin
        anyFree = 1'b1;
        allocSlot = TAG_W'(s);
      end
    end
  end

  always_comb begin
    tblSlot = '0;
    for (int s = MAX_OUT - 1; s >= 0; s--) begin
      hitVec[s] = fillValid && addrHit[s] &&
                  (slotSt[s] == SLOT_PEND || slotSt[s] == SLOT_SPEC);
      if (hitVec[s]) tblSlot = TAG_W'(s);
    end
    badFill = |(hitVec & ~dataEq);
  end

  assign predValid      = missValid && anyFree;
  assign missStall      = missValid && !anyFree;
  assign strobe.allocEn = predValid;
  assign strobe.tblWrEn = |hitVec;
  assign ckptReq        = (ctlSt == CTL_CKWAIT);

  always_comb begin
    nxtSt = slotSt;
    nxtCtl = ctlSt;
    nxtHeld = ckptHeld;
    nxtWait = waitTag;
    retireNow = 1'b0;
    retTagNow = '0;
    commitNow = 1'b0;
    anySpecNxt = 1'b0;
    // fill outcome
    for (int s = 0; s < MAX_OUT; s++) begin
      if (hitVec[s]) nxtSt[s] = (slotSt[s] == SLOT_SPEC) ? SLOT_FREE : SLOT_DONE;
    end
    // head of reorder buffer
    if (ctlSt == CTL_IDLE && robHeadValid) begin
      if (nxtSt[robHeadTag] == SLOT_DONE) begin
        nxtSt[robHeadTag] = SLOT_FREE;
        retireNow = 1'b1;
        retTagNow = robHeadTag;
      end else if (nxtSt[robHeadTag] == SLOT_PEND) begin
        if (ckptHeld) begin
          nxtSt[robHeadTag] = SLOT_SPEC;
          retireNow = 1'b1;
          retTagNow = robHeadTag;
        end else begin
          nxtCtl = CTL_CKWAIT;
          nxtWait = robHeadTag;
        end
      end
    end
    // checkpoint handshake
    if (ctlSt == CTL_CKWAIT && ckptAck) begin
      nxtCtl = CTL_IDLE;
      nxtHeld = 1'b1;
      retireNow = 1'b1;
      retTagNow = waitTag;
      nxtSt[waitTag] = (nxtSt[waitTag] == SLOT_DONE) ? SLOT_FREE : SLOT_SPEC;
    end
    // release of checkpoint
    for (int s = 0; s < MAX_OUT; s++) begin
      if (nxtSt[s] == SLOT_SPEC) anySpecNxt = 1'b1;
    end
    if (ckptHeld && !anySpecNxt && !badFill) begin
      commitNow = 1'b1;
      nxtHeld = 1'b0;
    end
    if (predValid) nxtSt[allocSlot] = SLOT_PEND;
    // mispredict clears everything
    if (badFill) begin
      for (int s = 0; s < MAX_OUT; s++) nxtSt[s] = SLOT_FREE;
      nxtCtl = CTL_IDLE;
      nxtHeld = 1'b0;
      retireNow = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < MAX_OUT; s++) slotSt[s] <= SLOT_FREE;
      ctlSt <= CTL_IDLE;
      ckptHeld <= 1'b0;
      waitTag <= '0;
      retireValid <= 1'b0;
      retireTag <= '0;
      commitValid <= 1'b0;
      rollbackValid <= 1'b0;
    end else begin
      slotSt <= nxtSt;
      ctlSt <= nxtCtl;
      ckptHeld <= nxtHeld;
      waitTag <= nxtWait;
      retireValid <= retireNow;
      retireTag <= retTagNow;
      commitValid <= commitNow;
      rollbackValid <= badFill;
    end
  end
endmodule

// File: rtl/miss_value_spec.sv
module miss_value_spec #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PC_W = 32,
  parameter int TBL_DEPTH = 64,
  parameter int MAX_OUT = 4,
  parameter int PC_LSB = 2,
  localparam int TAG_W = $clog2(MAX_OUT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [PC_W-1:0]   missPc,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              predValid,
  output logic [DATA_W-1:0] predValue,
  output logic [TAG_W-1:0]  predTag,
  output logic              missStall,
  input  logic              robHeadValid,
  input  logic [TAG_W-1:0]  robHeadTag,
  output logic              ckptReq,
  input  logic              ckptAck,
  output logic              retireValid,
  output logic [TAG_W-1:0]  retireTag,
  output logic [DATA_W-1:0] retireValue,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  output logic              commitValid,
  output logic              rollbackValid
);
  mvp_pkg::dpStrobe_t strobe;
  logic [TAG_W-1:0]   allocSlot, tblSlot;
  logic [MAX_OUT-1:0] addrHit, dataEq;

  assign predTag = allocSlot;

  mvp_control #(.MAX_OUT(MAX_OUT)) uCtl (
    .clk(clk), .rstN(rstN), .missValid(missValid),
    .robHeadValid(robHeadValid), .robHeadTag(robHeadTag), .ckptAck(ckptAck),
    .fillValid(fillValid), .addrHit(addrHit), .dataEq(dataEq),
    .strobe(strobe), .allocSlot(allocSlot), .tblSlot(tblSlot),
    .predValid(predValid), .missStall(missStall), .ckptReq(ckptReq),
    .retireValid(retireValid), .retireTag(retireTag),
    .commitValid(commitValid), .rollbackValid(rollbackValid)
  );

  mvp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W), .TBL_DEPTH(TBL_DEPTH),
    .MAX_OUT(MAX_OUT), .PC_LSB(PC_LSB)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocSlot(allocSlot),
    .tblSlot(tblSlot), .rdSlot(retireTag), .missPc(missPc), .missAddr(missAddr),
    .fillAddr(fillAddr), .fillData(fillData), .predValue(predValue),
    .addrHit(addrHit), .dataEq(dataEq), .rdValue(retireValue)
  );
endmodule

// File: rtl/mvp_checker.sv
module mvp_checker (
  input logic clk,
  input logic rstN,
  input logic predValid,
  input logic missStall,
  input logic ckptReq,
  input logic ckptAck,
  input logic retireValid,
  input logic commitValid,
  input logic rollbackValid
);
  // R3
  pred_stall_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> !missStall);
  // R4
  ckpt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ckptReq && !ckptAck) |=> (ckptReq || rollbackValid));
  // R5
  ack_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ckptReq && ckptAck) |=> (retireValid || rollbackValid));
  // R9
  rollback_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rollbackValid |-> (!commitValid && !retireValid));
  // R9
  rollback_req_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rollbackValid |-> !ckptReq);
endmodule

bind miss_value_spec mvp_checker uChk (
  .clk(clk), .rstN(rstN), .predValid(predValid), .missStall(missStall),
  .ckptReq(ckptReq), .ckptAck(ckptAck), .retireValid(retireValid),
  .commitValid(commitValid), .rollbackValid(rollbackValid)
);

// File: tb/tb_miss_value_spec.sv
`timescale 1ns/1ps
module tb_miss_value_spec;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [31:0] missPc = '0, missAddr = '0;
  logic predValid, missStall, ckptReq, retireValid, commitValid, rollbackValid;
  logic [31:0] predValue, retireValue;
  logic [1:0] predTag, retireTag;
  logic robHeadValid = 1'b0;
  logic [1:0] robHeadTag = '0;
  logic ckptAck = 1'b0;
  logic fillValid = 1'b0;
  logic [31:0] fillAddr = '0, fillData = '0;

  int checks = 0;
  int failures = 0;

  typedef struct packed { logic [1:0] kind; logic [1:0] tag; logic [31:0] val; } evt_t;
  localparam logic [1:0] EV_RET = 2'd0, EV_COM = 2'd1, EV_RBK = 2'd2;
  evt_t expQ[$];

  always #2.5 clk = ~clk;

  miss_value_spec dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missPc(missPc),
    .missAddr(missAddr), .predValid(predValid), .predValue(predValue),
    .predTag(predTag), .missStall(missStall), .robHeadValid(robHeadValid),
    .robHeadTag(robHeadTag), .ckptReq(ckptReq), .ckptAck(ckptAck),
    .retireValid(retireValid), .retireTag(retireTag), .retireValue(retireValue),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .commitValid(commitValid), .rollbackValid(rollbackValid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pushEv(input logic [1:0] k, input logic [1:0] t, input logic [31:0] v);
    evt_t e;
    e.kind = k; e.tag = t; e.val = v;
    expQ.push_back(e);
  endtask

  task automatic popCmp(input logic [1:0] k, input logic [1:0] t, input logic [31:0] v, input string req);
    evt_t e;
    if (expQ.size() == 0) begin
      chk(1'b0, req, {30'd0, k}, 32'hFFFF_FFFF);
    end else begin
      e = expQ.pop_front();
      chk(e.kind == k, req, {30'd0, k}, {30'd0, e.kind});
      if (k == EV_RET) begin
        chk(e.tag == t, "R5 retire tag", {30'd0, t}, {30'd0, e.tag});
        chk(e.val == v, "R5 retire value", v, e.val);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (retireValid) popCmp(EV_RET, retireTag, retireValue, "R5/R6/R7 retire event");
      if (commitValid) popCmp(EV_COM, 2'd0, 32'd0, "R8 commit event");
      if (rollbackValid) popCmp(EV_RBK, 2'd0, 32'd0, "R9/R10 rollback event");
    end
  end

  task automatic doMiss(input logic [31:0] pc, input logic [31:0] addr,
                        output logic pv, output logic [31:0] val,
                        output logic [1:0] tag, output logic st);
    missValid = 1'b1; missPc = pc; missAddr = addr;
    #1;
    pv = predValid; val = predValue; tag = predTag; st = missStall;
    @(posedge clk); #1;
    missValid = 1'b0;
  endtask

  task automatic doFill(input logic [31:0] addr, input logic [31:0] data);
    fillValid = 1'b1; fillAddr = addr; fillData = data;
    @(posedge clk); #1;
    fillValid = 1'b0;
  endtask

  task automatic doHead(input logic [1:0] tag);
    robHeadValid = 1'b1; robHeadTag = tag;
    @(posedge clk); #1;
    robHeadValid = 1'b0;
  endtask

  task automatic doAck();
    ckptAck = 1'b1;
    @(posedge clk); #1;
    ckptAck = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic pv, st;
    logic [31:0] v;
    logic [1:0] t;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // reset state
    chk(ckptReq == 1'b0, "R4 reset ckptReq", {31'd0, ckptReq}, 32'd0);
    chk(!retireValid && !commitValid && !rollbackValid, "R9 reset pulses",
        {29'd0, retireValid, commitValid, rollbackValid}, 32'd0);

    // early mismatch -> rollback, table trained
    doMiss(32'h40, 32'h1000, pv, v, t, st);
    chk(pv && v == 32'd0 && t == 2'd0, "R1 first prediction from reset table", v, 32'd0);
    pushEv(EV_RBK, 2'd0, 32'd0);
    doFill(32'h1000, 32'h55);
    idle(2);

    // checkpoint path and commit
    doMiss(32'h40, 32'h2000, pv, v, t, st);
    chk(v == 32'h55, "R2 table updated by fill", v, 32'h55);
    chk(t == 2'd0, "R9 entries cleared after rollback", {30'd0, t}, 32'd0);
    doHead(2'd0);
    chk(ckptReq == 1'b1, "R4 ckptReq raised", {31'd0, ckptReq}, 32'd1);
    idle(3);
    chk(ckptReq == 1'b1, "R4 ckptReq held until ack", {31'd0, ckptReq}, 32'd1);
    pushEv(EV_RET, 2'd0, 32'h55);
    doAck();
    chk(ckptReq == 1'b0, "R5 request dropped after ack", {31'd0, ckptReq}, 32'd0);
    pushEv(EV_COM, 2'd0, 32'd0);
    doFill(32'h2000, 32'h55);
    idle(2);

    // two loads under one checkpoint, younger mispredicts
    doMiss(32'h80, 32'h3000, pv, v, t, st);
    chk(t == 2'd0 && v == 32'd0, "R1 second pc index", v, 32'd0);
    doMiss(32'h40, 32'h4000, pv, v, t, st);
    chk(t == 2'd1 && v == 32'h55, "R1 lowest free tag", {30'd0, t}, 32'd1);
    doHead(2'd0);
    pushEv(EV_RET, 2'd0, 32'd0);
    doAck();
    pushEv(EV_RET, 2'd1, 32'h55);
    doHead(2'd1);
    chk(ckptReq == 1'b0, "R6 no new request under held checkpoint", {31'd0, ckptReq}, 32'd0);
    doFill(32'h3000, 32'd0);
    idle(2);
    pushEv(EV_RBK, 2'd0, 32'd0);
    doFill(32'h4000, 32'h99);
    idle(2);
    doMiss(32'h40, 32'h6000, pv, v, t, st);
    chk(v == 32'h99, "R2 table updated on mismatch", v, 32'h99);
    pushEv(EV_RBK, 2'd0, 32'd0);
    doFill(32'h6000, 32'h1);
    idle(2);

    // early matching fill skips checkpoint
    doMiss(32'h40, 32'h5000, pv, v, t, st);
    chk(v == 32'h1 && t == 2'd0, "R7 prediction", v, 32'h1);
    doFill(32'h5000, 32'h1);
    idle(2);
    pushEv(EV_RET, 2'd0, 32'h1);
    doHead(2'd0);
    chk(ckptReq == 1'b0, "R7 no checkpoint for verified load", {31'd0, ckptReq}, 32'd0);
    idle(2);
    chk(ckptReq == 1'b0, "R7 still no checkpoint", {31'd0, ckptReq}, 32'd0);

    // capacity
    for (int i = 0; i < 4; i++) begin
      doMiss(32'h100 + 32'(i * 4), 32'hA000 + 32'(i * 16), pv, v, t, st);
      chk(pv && !st && t == 2'(i), "R3 entry allocated", {30'd0, t}, 32'(i));
    end
    doMiss(32'h200, 32'hB000, pv, v, t, st);
    chk(!pv && st, "R3 stall when full", {30'd0, pv, st}, 32'd1);
    doFill(32'hBEEF0, 32'h7);
    idle(2);
    chk(expQ.size() == 0, "R10 unmatched fill no event", 32'(expQ.size()), 32'd0);
    pushEv(EV_RBK, 2'd0, 32'd0);
    doFill(32'hA000, 32'h123);
    idle(2);

    // rollback withdraws a pending request
    doMiss(32'h200, 32'hC000, pv, v, t, st);
    chk(t == 2'd0 && v == 32'h123, "R9 cleared entries and R2 index 0", v, 32'h123);
    doHead(2'd0);
    chk(ckptReq == 1'b1, "R4 request raised", {31'd0, ckptReq}, 32'd1);
    pushEv(EV_RBK, 2'd0, 32'd0);
    doFill(32'hC000, 32'h5);
    chk(ckptReq == 1'b0, "R9 request withdrawn", {31'd0, ckptReq}, 32'd0);
    idle(3);

    chk(expQ.size() == 0, "R8 all expected events seen", 32'(expQ.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule